// File: doc/BRIEF.md
# Byte-Staging Memory Copy Engine

This block moves a run of bytes from one memory region to another without involving the processor. It pairs two address channels, a source channel and a destination channel. Every byte takes two bus cycles. The first cycle reads the byte at the source address into an internal one-byte staging register. The second cycle writes that register to the destination address. Because data always passes through the staging register, only 8-bit copies are possible.

A copy begins when `start` is pulsed while the engine is idle. At that moment the engine captures the two start addresses, the byte count, and one step direction for each address. After each byte the two addresses step on their own, one up and one down if so selected. The source can also be held still, which fills a region with a single byte value. The copy ends when the byte count reaches zero, or after the write in progress when `abort` is raised. The engine then raises `done` for one cycle and drops `busy` in that same cycle.

Top module: `mcopy_engine`

## Requirements
- R1: While reset is applied and in the first cycle after it, `busy`, `done`, `mem_rd` and `mem_wr` are all low.
- R2: A `start` seen while idle (`busy` and `done` both low) with a non-zero count puts a read cycle on the bus in the very next cycle: `mem_rd` is 1 and `mem_addr` equals the captured source address.
- R3: Each byte uses a read cycle followed directly by a write cycle. `mem_rd` and `mem_wr` are never high together. The `mem_wdata` of the write equals the `mem_rdata` that was present during the read.
- R4: After each byte the source address steps by +1, or by -1 when `src_dec` was 1 at start. It wraps modulo 2^ADDR_W.
- R5: After each byte the destination address steps by +1, or by -1 when `dst_dec` was 1 at start. It wraps modulo 2^ADDR_W and does not depend on the source direction.
- R6: When `src_hold` was 1 at start, every read uses the starting source address, so the destination region fills with one byte.
- R7: A copy of N bytes keeps `busy` high for exactly 2N consecutive cycles and moves exactly N bytes. An overlapping copy gives the same memory contents as copying the bytes one at a time in order.
- R8: `done` is high for exactly one cycle, in the cycle right after the last write, and `busy` is low in that cycle.
- R9: A start with a count of 0 performs no bus cycle and raises `done` in the next cycle.
- R10: When `abort` is high in any busy cycle, the byte in progress is still written and no further byte is started.
- R11: A `start` that arrives while a copy is running is ignored. The addresses, count and data of the running copy do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse, accepted only when idle |
| src_addr_in | input | ADDR_W | First source address |
| dst_addr_in | input | ADDR_W | First destination address |
| count_in | input | CNT_W | Number of bytes to copy |
| src_dec | input | 1 | 1: source address steps down |
| dst_dec | input | 1 | 1: destination address steps down |
| src_hold | input | 1 | 1: source address stays fixed |
| abort | input | 1 | End the copy after the current write |
| mem_rdata | input | 8 | Read data from memory, valid during the read cycle |
| mem_addr | output | ADDR_W | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data, taken from the staging register |
| busy | output | 1 | A copy is in progress |
| done | output | 1 | One-cycle end-of-copy pulse |

## Verification
The bench builds the engine with ADDR_W=8 and CNT_W=8, so the whole 256-byte address space is modelled in the bench and is compared in full after every copy. This small size puts address wrap at both ends within reach of short runs. It also makes it cheap to sweep all eight combinations of the two directions and the hold flag, over overlapping and non-overlapping regions. An abort is tried in every busy cycle of a short copy, and a count of zero is covered as a separate case.

// File: rtl/mcopy_pkg.sv
package mcopy_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2,
      ST_FIN   = 2'd3
   } mc_state_t;

   localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/mcopy_addr_ctr.sv
module mcopy_addr_ctr #(
   parameter int unsigned AW      = 16,
   parameter bit          HOLD_EN = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          dec_in,
   input  logic          hold_in,
   input  logic          step,
   output logic [AW-1:0] addr
);
   localparam logic [AW-1:0] ONE = AW'(1);

   logic dec_q;
   logic hold_eff;

   generate
      if (HOLD_EN) begin : g_hold
         logic hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    hold_q <= 1'b0;
            else if (load) hold_q <= hold_in;
         end
         assign hold_eff = hold_q;
      end else begin : g_nohold
         logic unused_hold;
         assign unused_hold = hold_in;
         assign hold_eff    = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr  <= '0;
         dec_q <= 1'b0;
      end else if (load) begin
         addr  <= load_val;
         dec_q <= dec_in;
      end else if (step && !hold_eff) begin
         addr  <= dec_q ? addr - ONE : addr + ONE;
      end
   end
endmodule

// File: rtl/mcopy_seq.sv
module mcopy_seq
   import mcopy_pkg::*;
#(
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] count_in,
   input  logic          abort,
   output logic          load,
   output logic          step,
   output logic          rd,
   output logic          wr,
   output logic          busy,
   output logic          done
);
   localparam logic [CW-1:0] ONE = CW'(1);

   mc_state_t     state_q;
   mc_state_t     state_d;
   logic [CW-1:0] cnt_q;
   logic          abort_q;
   logic          last_byte;

   assign load      = (state_q == ST_IDLE) && start;
   assign rd        = (state_q == ST_READ);
   assign wr        = (state_q == ST_WRITE);
   assign step      = wr;
   assign busy      = rd || wr;
   assign done      = (state_q == ST_FIN);
   assign last_byte = (cnt_q == ONE) || abort_q || abort;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (start) state_d = (count_in == '0) ? ST_FIN : ST_READ;
         ST_READ:  state_d = ST_WRITE;
         ST_WRITE: state_d = last_byte ? ST_FIN : ST_READ;
         ST_FIN:   state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         abort_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (load) begin
            cnt_q   <= count_in;
            abort_q <= 1'b0;
         end else begin
            if (step)         cnt_q   <= cnt_q - ONE;
            if (busy && abort) abort_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/mcopy_engine.sv
module mcopy_engine
   import mcopy_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] src_addr_in,
   input  logic [ADDR_W-1:0] dst_addr_in,
   input  logic [CNT_W-1:0]  count_in,
   input  logic              src_dec,
   input  logic              dst_dec,
   input  logic              src_hold,
   input  logic              abort,
   input  logic [7:0]        mem_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [7:0]        mem_wdata,
   output logic              busy,
   output logic              done
);
   generate
      if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_aw
         $error("mcopy_engine: ADDR_W out of range");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cw
         $error("mcopy_engine: CNT_W out of range");
      end
      if (BYTE_W != 8) begin : g_bad_bw
         $error("mcopy_engine: staging register must be one byte");
      end
   endgenerate

   logic              load, step;
   logic [ADDR_W-1:0] src_addr, dst_addr;
   logic [7:0]        stage_q;

   mcopy_seq #(.CW(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .count_in(count_in),
      .abort(abort), .load(load), .step(step), .rd(mem_rd), .wr(mem_wr),
      .busy(busy), .done(done)
   );

   mcopy_addr_ctr #(.AW(ADDR_W), .HOLD_EN(1'b1)) u_src (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(src_addr_in),
      .dec_in(src_dec), .hold_in(src_hold), .step(step), .addr(src_addr)
   );

   mcopy_addr_ctr #(.AW(ADDR_W), .HOLD_EN(1'b0)) u_dst (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(dst_addr_in),
      .dec_in(dst_dec), .hold_in(1'b0), .step(step), .addr(dst_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stage_q <= '0;
      else if (mem_rd) stage_q <= mem_rdata;
   end

   assign mem_addr  = mem_wr ? dst_addr : src_addr;
   assign mem_wdata = stage_q;
endmodule

// File: rtl/mcopy_engine_chk.sv
module mcopy_engine_chk #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [ADDR_W-1:0] src_addr_in,
   input logic [CNT_W-1:0]  count_in,
   input logic [7:0]        mem_rdata,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic [7:0]        mem_wdata,
   input logic              busy,
   input logic              done
);
   logic idle;
   assign idle = !busy && !done;

   AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr)); // R3
   AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> mem_wr); // R3
   AST_WDATA_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (mem_wdata == $past(mem_rdata))); // R3
   AST_FIRST_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (start && idle && count_in != '0) |=> (mem_rd && mem_addr == $past(src_addr_in))); // R2
   AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (start && idle && count_in == '0) |=> (done && !mem_rd && !mem_wr)); // R9
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_DONE_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !mem_rd && !mem_wr)); // R8
   AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> busy); // R7
endmodule

bind mcopy_engine mcopy_engine_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .src_addr_in(src_addr_in),
   .count_in(count_in), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
   .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
   .busy(busy), .done(done)
);

// File: tb/mcopy_engine_test.sv
module mcopy_engine_test;
   localparam int AW = 8;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] src_addr_in = '0, dst_addr_in = '0;
   logic [CW-1:0] count_in = '0;
   logic          src_dec = 1'b0, dst_dec = 1'b0, src_hold = 1'b0, abort = 1'b0;
   logic [7:0]    mem_rdata;
   logic [AW-1:0] mem_addr;
   logic          mem_rd, mem_wr, busy, done;
   logic [7:0]    mem_wdata;

   logic [7:0] mem [256];
   logic [7:0] ref_mem [256];
   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   mcopy_engine #(.ADDR_W(AW), .CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .src_addr_in(src_addr_in),
      .dst_addr_in(dst_addr_in), .count_in(count_in), .src_dec(src_dec),
      .dst_dec(dst_dec), .src_hold(src_hold), .abort(abort),
      .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .mem_wdata(mem_wdata), .busy(busy), .done(done)
   );

   assign mem_rdata = mem[mem_addr];
   always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // abort_at < 0: no abort; poke_start: a second start in busy cycle 1 (R11)
   task automatic run(input int s0, input int d0, input int n, input bit sd,
                      input bit dd, input bit hd, input int abort_at, input bit poke_start);
      int nexp, j, k, bad_addr, bad_mem;
      int sa [256];
      int da [256];
      nexp = n;
      if (abort_at >= 0 && abort_at / 2 + 1 < n) nexp = abort_at / 2 + 1;
      for (int i = 0; i < 256; i++) ref_mem[i] = mem[i];
      for (int b = 0; b < nexp; b++) begin
         sa[b] = hd ? s0 : (sd ? (s0 - b) & 255 : (s0 + b) & 255);
         da[b] = dd ? (d0 - b) & 255 : (d0 + b) & 255;
         ref_mem[da[b]] = ref_mem[sa[b]];
      end
      @(negedge clk);
      src_addr_in = AW'(s0); dst_addr_in = AW'(d0); count_in = CW'(n);
      src_dec = sd; dst_dec = dd; src_hold = hd; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      j = 0; bad_addr = 0;
      while (busy && j < 1200) begin
         k = j / 2;
         if ((j % 2) == 0) begin
            if (!mem_rd || mem_wr || k >= nexp || mem_addr != AW'(sa[k])) bad_addr++;
         end else begin
            if (!mem_wr || mem_rd || k >= nexp || mem_addr != AW'(da[k])) bad_addr++;
         end
         abort = (j == abort_at);
         if (poke_start && j == 1) begin
            start = 1'b1; src_addr_in = AW'(s0 + 77); count_in = CW'(n + 3);
         end else start = 1'b0;
         @(negedge clk);
         j++;
      end
      abort = 1'b0; start = 1'b0;
      check(j < 1200, "watchdog", j, 2 * nexp);
      check(bad_addr == 0, "R3/R4/R5/R6 bus cycle order and addresses", bad_addr, 0);
      check(j == 2 * nexp, abort_at >= 0 ? "R10 busy length after abort" :
            (n == 0 ? "R9 no bus cycles" : "R7 busy length"), j, 2 * nexp);
      check(done == 1'b1 && busy == 1'b0, "R8 done after last write", int'(done), 1);
      bad_mem = 0;
      for (int i = 0; i < 256; i++) if (mem[i] != ref_mem[i]) bad_mem++;
      check(bad_mem == 0, hd ? "R6 fill contents" : "R7 memory contents", bad_mem, 0);
      @(negedge clk);
      check(done == 1'b0 && busy == 1'b0, "R8 done lasts one cycle", int'(done), 0);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
      repeat (3) @(negedge clk);
      check(!busy && !done && !mem_rd && !mem_wr, "R1 during reset",
            int'({busy, done, mem_rd, mem_wr}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && !mem_rd && !mem_wr, "R1 after reset",
            int'({busy, done, mem_rd, mem_wr}), 0);
      // R4 R5 R6 R7: every direction/hold combination, with wrap at both ends
      for (int m = 0; m < 8; m++) begin
         run(250, 3, 9, m[0], m[1], m[2], -1, 1'b0);
         run(5, 120, 17, m[0], m[1], m[2], -1, 1'b0);
      end
      // R7: overlapping regions, forward and backward
      run(40, 43, 20, 1'b0, 1'b0, 1'b0, -1, 1'b0);
      run(60, 57, 20, 1'b1, 1'b1, 1'b0, -1, 1'b0);
      run(10, 200, 1, 1'b0, 1'b0, 1'b0, -1, 1'b0);
      run(0, 128, 255, 1'b0, 1'b0, 1'b0, -1, 1'b0);
      // R9
      run(30, 90, 0, 1'b0, 1'b0, 1'b0, -1, 1'b0);
      // R10: abort in each busy cycle of a 4-byte copy
      for (int a = 0; a < 8; a++) run(100, 180 + a, 4, 1'b0, 1'b0, 1'b0, a, 1'b0);
      // R11: start pulsed while busy
      run(70, 150, 6, 1'b0, 1'b1, 1'b0, -1, 1'b1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule